// File: doc/BRIEF.md
# Keypad Numeric Parameter Entry

This block sits between a keypad decoder and a small menu controller on a control panel. It takes one decoded key code per key-valid strobe. From these it builds a signed decimal number, digit by digit. It also issues single-cycle menu events: confirm (carrying the finished number), abort to the start screen, step to the next parameter, and increase or decrease the selected parameter.

Two keys change meaning with the state of the entry. The zero key clears the entry when no digit has been typed yet, and adds a zero digit otherwise. The minus key marks the number as negative when no digit has been typed yet, and asks for a decrease otherwise. The digit count and the sign flag are outputs, so that a character display can show the number as it is typed.

Top module: `kp_param_entry`

## Requirements
- R1: Key codes 1 to 9 (code value equals the digit) each append one decimal digit: the magnitude becomes magnitude*10 + digit and the digit count rises by one.
- R2: Key code 0 clears the magnitude, the sign and the count when the count is 0. Otherwise it appends a zero digit.
- R3: With MAX_DIGITS (default 5) digits held, digit keys 0 to 9 change nothing until a digit is removed, or the entry is confirmed or aborted.
- R4: Key code 12 (backspace) divides the magnitude by 10, dropping the remainder, and lowers the count by one. At count 0 it has no effect.
- R5: Key code 15 (minus) sets the sign flag and emits no event when the count is 0. Otherwise it emits a decrement pulse and leaves the entry unchanged.
- R6: Key code 11 (enter) emits a confirm pulse with the signed value held before the key on the confirm-value port, and clears the entry in the same cycle.
- R7: Key code 10 (home) emits an abort pulse and clears the magnitude, the sign and the count.
- R8: Key code 13 emits a select pulse and key code 14 emits an increment pulse. Neither changes the entry.
- R9: Each event pulse is high for exactly one cycle, in the cycle after the strobed key. At most one event is high at a time. With no strobe, no event occurs and the entry does not change.
- R10: After synchronous reset the value is 0, the count is 0, the sign flag is clear and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_code | input | 4 | Decoded key code |
| key_vld | input | 1 | One-cycle strobe qualifying key_code |
| entry_value | output | VAL_W (18) | Signed value being entered |
| entry_neg | output | 1 | Sign flag of the entry |
| digit_cnt | output | CNT_W (3) | Digits currently held |
| conf_pulse | output | 1 | Confirm event |
| conf_value | output | VAL_W (18) | Value carried with the confirm event |
| abort_pulse | output | 1 | Abort / return-to-start event |
| sel_pulse | output | 1 | Next-parameter event |
| inc_pulse | output | 1 | Increment event |
| dec_pulse | output | 1 | Decrement event |

## Verification
The hardest cases to reach are those where a key's meaning depends on the entry state. These are a zero or minus key at count 0 as opposed to mid-entry, a digit arriving at a full entry, and backspace on an empty or negative-only entry. The stimulus builds each state on purpose. It types exactly MAX_DIGITS digits and then more, presses minus both before and after digits, and backspaces past empty. A bench model, built from the requirements, tracks the expected magnitude, sign and count after every key. A sweep over all two-digit entries, positive and negative, then confirms each value.

// File: rtl/kp_pkg.sv
package kp_pkg;

    localparam int unsigned KP_MAX_DIGITS = 5;

    localparam logic [3:0] KC_HOME  = 4'd10;
    localparam logic [3:0] KC_ENTER = 4'd11;
    localparam logic [3:0] KC_BKSP  = 4'd12;
    localparam logic [3:0] KC_SEL   = 4'd13;
    localparam logic [3:0] KC_PLUS  = 4'd14;
    localparam logic [3:0] KC_MINUS = 4'd15;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_APPEND,
        ACT_CLEAR,
        ACT_DROP,
        ACT_SIGN,
        ACT_CONFIRM,
        ACT_ABORT
    } act_e;

    typedef struct packed {
        logic confirm;
        logic abort;
        logic sel;
        logic inc;
        logic dec;
    } evt_t;

    typedef struct packed {
        act_e       act;
        logic [3:0] digit;
        evt_t       evt;
    } cmd_t;

    function automatic logic is_digit(input logic [3:0] code);
        return code <= 4'd9;
    endfunction

endpackage

// File: rtl/kp_key_decode.sv
module kp_key_decode
    import kp_pkg::*;
(
    input  logic [3:0] key_code,
    input  logic       key_vld,
    input  logic       empty,
    input  logic       full,
    output cmd_t       cmd
);

    always_comb begin
        cmd.act   = ACT_NONE;
        cmd.digit = key_code;
        cmd.evt   = '0;
        if (key_vld) begin
            if (is_digit(key_code)) begin
                if (key_code == 4'd0 && empty)
                    cmd.act = ACT_CLEAR;
                else if (!full)
                    cmd.act = ACT_APPEND;
            end else begin
                case (key_code)
                    KC_HOME: begin
                        cmd.act       = ACT_ABORT;
                        cmd.evt.abort = 1'b1;
                    end
                    KC_ENTER: begin
                        cmd.act         = ACT_CONFIRM;
                        cmd.evt.confirm = 1'b1;
                    end
                    KC_BKSP: begin
                        if (!empty) cmd.act = ACT_DROP;
                    end
                    KC_SEL:  cmd.evt.sel = 1'b1;
                    KC_PLUS: cmd.evt.inc = 1'b1;
                    KC_MINUS: begin
                        if (empty) cmd.act = ACT_SIGN;
                        else       cmd.evt.dec = 1'b1;
                    end
                    default: cmd.act = ACT_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/kp_entry_accum.sv
module kp_entry_accum
    import kp_pkg::*;
#(
    parameter int unsigned MAX_DIGITS = KP_MAX_DIGITS,
    parameter int unsigned MAG_W      = 17,
    parameter int unsigned CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    input  logic [3:0]       digit,
    output logic [MAG_W-1:0] mag,
    output logic             neg,
    output logic [CNT_W-1:0] cnt
);

    localparam int unsigned EXT_W = MAG_W + 4;

    logic [EXT_W-1:0] appended;
    logic [MAG_W-1:0] dropped;

    always_comb begin
        appended = EXT_W'(mag) * EXT_W'(10) + EXT_W'(digit);
        dropped  = mag / MAG_W'(10);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag <= '0;
            neg <= 1'b0;
            cnt <= '0;
        end else begin
            case (act)
                ACT_APPEND: begin
                    mag <= MAG_W'(appended);
                    cnt <= cnt + CNT_W'(1);
                end
                ACT_DROP: begin
                    mag <= dropped;
                    cnt <= cnt - CNT_W'(1);
                end
                ACT_SIGN: neg <= 1'b1;
                ACT_CLEAR, ACT_CONFIRM, ACT_ABORT: begin
                    mag <= '0;
                    neg <= 1'b0;
                    cnt <= '0;
                end
                default: ;
            endcase
        end
    end

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_DIGITS));

    a_r4_drop_step: assert property (@(posedge clk) disable iff (rst)
        act == ACT_DROP |=> cnt == $past(cnt) - CNT_W'(1));

    a_r1_append_step: assert property (@(posedge clk) disable iff (rst)
        act == ACT_APPEND |=> cnt == $past(cnt) + CNT_W'(1));

    a_r7_abort_clears: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ABORT |=> (cnt == '0 && mag == '0 && !neg));

endmodule

// File: rtl/kp_event_pulse.sv
module kp_event_pulse
    import kp_pkg::*;
#(
    parameter int unsigned VAL_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_vld,
    input  evt_t             evt_in,
    input  logic [VAL_W-1:0] value_in,
    output evt_t             evt_q,
    output logic [VAL_W-1:0] conf_value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q      <= '0;
            conf_value <= '0;
        end else begin
            evt_q <= evt_in;
            if (evt_in.confirm) conf_value <= value_in;
        end
    end

    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_q));

    a_r9_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        !key_vld |=> evt_q == '0);

endmodule

// File: rtl/kp_param_entry.sv
module kp_param_entry
    import kp_pkg::*;
#(
    parameter int unsigned MAX_DIGITS = KP_MAX_DIGITS,
    parameter int unsigned MAG_W      = $clog2(10 ** MAX_DIGITS),
    parameter int unsigned VAL_W      = MAG_W + 1,
    parameter int unsigned CNT_W      = $clog2(MAX_DIGITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       key_code,
    input  logic             key_vld,
    output logic [VAL_W-1:0] entry_value,
    output logic             entry_neg,
    output logic [CNT_W-1:0] digit_cnt,
    output logic             conf_pulse,
    output logic [VAL_W-1:0] conf_value,
    output logic             abort_pulse,
    output logic             sel_pulse,
    output logic             inc_pulse,
    output logic             dec_pulse
);

    cmd_t             cmd;
    evt_t             evt_q;
    logic [MAG_W-1:0] mag;
    logic             neg;
    logic [CNT_W-1:0] cnt;
    logic             empty;
    logic             full;
    logic signed [VAL_W-1:0] pos_val;

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(MAX_DIGITS));

    kp_key_decode u_dec (
        .key_code (key_code),
        .key_vld  (key_vld),
        .empty    (empty),
        .full     (full),
        .cmd      (cmd)
    );

    kp_entry_accum #(
        .MAX_DIGITS (MAX_DIGITS),
        .MAG_W      (MAG_W),
        .CNT_W      (CNT_W)
    ) u_acc (
        .clk   (clk),
        .rst   (rst),
        .act   (cmd.act),
        .digit (cmd.digit),
        .mag   (mag),
        .neg   (neg),
        .cnt   (cnt)
    );

    always_comb begin
        pos_val     = $signed({1'b0, mag});
        entry_value = neg ? -pos_val : pos_val;
    end

    kp_event_pulse #(
        .VAL_W (VAL_W)
    ) u_evt (
        .clk        (clk),
        .rst        (rst),
        .key_vld    (key_vld),
        .evt_in     (cmd.evt),
        .value_in   (entry_value),
        .evt_q      (evt_q),
        .conf_value (conf_value)
    );

    assign entry_neg   = neg;
    assign digit_cnt   = cnt;
    assign conf_pulse  = evt_q.confirm;
    assign abort_pulse = evt_q.abort;
    assign sel_pulse   = evt_q.sel;
    assign inc_pulse   = evt_q.inc;
    assign dec_pulse   = evt_q.dec;

    a_r6_confirm_clears: assert property (@(posedge clk) disable iff (rst)
        conf_pulse |-> (digit_cnt == '0 && !entry_neg));

    a_r8_sel_keeps_entry: assert property (@(posedge clk) disable iff (rst)
        (sel_pulse || inc_pulse) |-> $stable(entry_value));

    a_r5_dec_keeps_entry: assert property (@(posedge clk) disable iff (rst)
        dec_pulse |-> ($stable(digit_cnt) && digit_cnt != '0));

endmodule

// File: tb/kp_param_entry_test.sv
module kp_param_entry_test;

    localparam int MAXD = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  key_code;
    logic        key_vld;
    logic [17:0] entry_value;
    logic        entry_neg;
    logic [2:0]  digit_cnt;
    logic        conf_pulse;
    logic [17:0] conf_value;
    logic        abort_pulse, sel_pulse, inc_pulse, dec_pulse;

    int n_chk  = 0;
    int n_fail = 0;

    longint m_mag;
    bit     m_neg;
    int     m_cnt;

    kp_param_entry uut (
        .clk         (clk),
        .rst         (rst),
        .key_code    (key_code),
        .key_vld     (key_vld),
        .entry_value (entry_value),
        .entry_neg   (entry_neg),
        .digit_cnt   (digit_cnt),
        .conf_pulse  (conf_pulse),
        .conf_value  (conf_value),
        .abort_pulse (abort_pulse),
        .sel_pulse   (sel_pulse),
        .inc_pulse   (inc_pulse),
        .dec_pulse   (dec_pulse)
    );

    always #5ns clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint m_val();
        return m_neg ? -m_mag : m_mag;
    endfunction

    task automatic check_entry(input string req);
        check($signed(entry_value) == m_val(), req, "value",
              longint'($signed(entry_value)), m_val());
        check(int'(digit_cnt) == m_cnt, req, "count", digit_cnt, m_cnt);
        check(entry_neg == m_neg, req, "sign", entry_neg, m_neg);
    endtask

    task automatic check_pulses(input string req, input bit c, input bit a,
                                input bit s, input bit i, input bit d);
        check({conf_pulse, abort_pulse, sel_pulse, inc_pulse, dec_pulse} == {c, a, s, i, d},
              req, "events",
              {conf_pulse, abort_pulse, sel_pulse, inc_pulse, dec_pulse},
              {c, a, s, i, d});
    endtask

    task automatic press(input int k);
        string  req;
        bit     ec, ea, es, ei, ed;
        longint cval;
        ec = 0; ea = 0; es = 0; ei = 0; ed = 0;
        cval = m_val();
        if (k <= 9) begin
            if (k == 0 && m_cnt == 0) begin
                req = "R2"; m_mag = 0; m_neg = 0;
            end else if (m_cnt >= MAXD) begin
                req = "R3";
            end else begin
                req = (k == 0) ? "R2" : "R1";
                m_mag = m_mag * 10 + k; m_cnt++;
            end
        end else if (k == 10) begin
            req = "R7"; ea = 1; m_mag = 0; m_neg = 0; m_cnt = 0;
        end else if (k == 11) begin
            req = "R6"; ec = 1; m_mag = 0; m_neg = 0; m_cnt = 0;
        end else if (k == 12) begin
            req = "R4";
            if (m_cnt > 0) begin m_mag = m_mag / 10; m_cnt--; end
        end else if (k == 13) begin
            req = "R8"; es = 1;
        end else if (k == 14) begin
            req = "R8"; ei = 1;
        end else begin
            req = "R5";
            if (m_cnt == 0) m_neg = 1; else ed = 1;
        end
        @(negedge clk);
        key_code = 4'(k);
        key_vld  = 1'b1;
        @(negedge clk);
        key_vld  = 1'b0;
        check_pulses(req, ec, ea, es, ei, ed);
        if (ec) check($signed(conf_value) == cval, "R6", "confirm value",
                      longint'($signed(conf_value)), cval);
        check_entry(req);
        @(negedge clk);
        check_pulses("R9", 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; key_code = '0; key_vld = 1'b0;
        m_mag = 0; m_neg = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check_entry("R10");
        check_pulses("R10", 0, 0, 0, 0, 0);

        // R1 R2 sweep of all two-digit entries, both signs, confirmed
        for (int a = 1; a <= 9; a++) begin
            for (int b = 0; b <= 9; b++) begin
                if (b[0]) press(15);
                press(a);
                press(b);
                press(11);
            end
        end

        // R3 fill past the limit, then remove and refill
        for (int i = 1; i <= 7; i++) press(i);
        press(0);
        press(12);
        press(8);
        press(9);
        press(11);

        // R4 backspace down past empty, with sign set
        press(15);
        press(4);
        press(2);
        for (int i = 0; i < 4; i++) press(12);
        press(7);
        press(11);

        // R2 zero at empty clears the sign; zero mid-entry appends
        press(15);
        press(0);
        press(3);
        press(0);
        press(0);
        press(11);

        // R5 minus mid-entry is a decrement; R8 select and increment
        press(6);
        press(15);
        press(13);
        press(14);
        press(15);
        // R7 home clears
        press(10);
        press(13);
        press(14);
        press(15);
        press(15);
        press(10);

        // R9 key codes without a strobe change nothing
        press(5);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            key_code = 4'(k);
            @(negedge clk);
            check_pulses("R9", 0, 0, 0, 0, 0);
            check_entry("R9");
        end
        press(11);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule